// File: doc/BRIEF.md
# Asynchronous PSRAM Byte-Lane Controller

This block lets an on-chip requester use an external 128K x 16 asynchronous pseudo-static RAM as ordinary word storage with byte masking. The requester offers one operation at a time on a valid/ready handshake: a 17-bit word address, a read/write flag, a 16-bit write word and two byte-enable bits. Reads come back as a registered word with a one-cycle valid pulse.

On the memory side the controller drives the two chip selects (one active low, one active high), the active-low write strobe, output enable and the two active-low lane enables. The data bus is given as a split pair, an output word with a registered drive enable and an input word, for a pad-level tri-state buffer. Every analogue timing (access, cycle, strobe width, data setup, bus release) is a nanosecond parameter. The controller converts each one into a whole number of controller clock cycles by rounding up, so any nonzero time takes at least one cycle. With the defaults (10 ns clock) a read holds the bus for 7 cycles and a write holds the strobe low for 6 cycles and then one closing cycle.

Lane encoding on the host side: `req_be[0]` selects data bits 7:0 and `req_be[1]` selects bits 15:8. On the memory side `mem_ble_n` is the active-low enable of bits 7:0 and `mem_bhe_n` that of bits 15:8.

Top module: `psram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the memory is deselected: `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, both lane enables high and `mem_dq_oe`=0. `req_ready` is 1 after reset.
- R2: A read drives `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1. `mem_ble_n` is low exactly when `req_be[0]` was set and `mem_bhe_n` exactly when `req_be[1]` was set. `mem_addr` does not change while `mem_oe_n` stays low.
- R3: The read strobes stay asserted for the largest of the rounded access, chip-enable, output-enable and read-cycle times (7 cycles by default). The bus is sampled on the edge that ends that window. `rsp_valid` is high for exactly one cycle, 8 cycles after the acceptance edge by default. In `rsp_rdata` the lanes that were not enabled read as zero.
- R4: A write drives the chip selects active and `mem_we_n` low, with the write word on `mem_dq_out` and `mem_dq_oe`=1. The strobe stays low for the largest of the rounded strobe-width, data-setup, chip-select-to-end, lane-enable-to-end and address-to-end times (6 cycles by default). Only enabled lanes change in memory; a disabled lane keeps its stored byte.
- R5: Every write ends on the rising edge of `mem_we_n`. In that cycle the chip selects, the requested lane enables and the data drive are still active. They stay active for max(1, write-cycle count minus strobe count) cycles.
- R6: `mem_dq_oe` is never 1 in a cycle with `mem_oe_n`=0. After `mem_oe_n` returns high, at least the rounded bus-release time (3 cycles by default) passes before `mem_dq_oe` rises.
- R7: `req_ready` drops on the acceptance edge for the whole operation. By default that is 10 cycles for a read (access window plus release window) and 7 cycles for a write (strobe plus closing cycle).
- R8: A request with both `req_be` bits clear is accepted with no bus cycle. The chip selects stay inactive, `req_ready` stays high, no response is produced and memory content is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 17 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bhe_n | output | 1 | Lane enable for bits 15:8, active low |
| mem_ble_n | output | 1 | Lane enable for bits 7:0, active low |
| mem_dq_out | output | 16 | Data to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The hardest case to reach is a write that follows directly after a read, where the bus-release wait is the only thing between the memory's output drivers and the controller's. Each sweep round writes every test address with one lane mask and then reads every address back with all three nonzero masks. That puts a read-to-write and a write-to-read transition at each round boundary. The memory model in the bench returns filler until the access count has run out, so a controller that samples too early shows up as wrong data. A second hard case is a disabled lane that must stay unchanged. Rewriting the same addresses with different masks leaves mixed old and new bytes, and the bench predicts those arithmetically.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WEND   = 3'd3,
    ST_REL    = 3'd4
  } psram_st_e;

  // nanoseconds to clock cycles, rounded up (nonzero gives at least one)
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned clk_ns);
    if (t_ns == 0) return 0;
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_cyc_timer.sv
module psram_cyc_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD  = 7,
  parameter int unsigned N_WP  = 6,
  parameter int unsigned N_WE  = 1,
  parameter int unsigned N_REL = 3,
  parameter int unsigned CW    = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_write,
  input  logic [1:0] req_be,
  output logic      req_ready,
  output logic      start,
  output logic      cap_en,
  output psram_st_e st_d
);

  psram_st_e     st_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          accept;

  psram_cyc_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && (req_be != 2'b00);
  assign cap_en    = (st_q == ST_READ) && tmr_done;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: if (start) begin
        tmr_load = 1'b1;
        if (req_write) begin
          st_d    = ST_WPULSE;
          tmr_val = CW'(N_WP - 1);
        end else begin
          st_d    = ST_READ;
          tmr_val = CW'(N_RD - 1);
        end
      end
      ST_READ: if (tmr_done) begin
        st_d     = ST_REL;
        tmr_load = 1'b1;
        tmr_val  = CW'(N_REL - 1);
      end
      ST_WPULSE: if (tmr_done) begin
        st_d     = ST_WEND;
        tmr_load = 1'b1;
        tmr_val  = CW'(N_WE - 1);
      end
      ST_WEND: if (tmr_done) st_d = ST_IDLE;
      ST_REL:  if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_NOOP_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == 2'b00) |=> req_ready); // R8

endmodule

// File: rtl/psram_pin_reg.sv
module psram_pin_reg
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned AW    = 17,
  parameter int unsigned LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  psram_st_e          st_d,
  input  logic               start,
  input  logic               cap_en,
  input  logic [AW-1:0]      req_addr,
  input  logic [LANES*8-1:0] req_wdata,
  input  logic [LANES-1:0]   req_be,
  input  logic [LANES*8-1:0] mem_dq_in,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_ce_n,
  output logic               mem_ce2,
  output logic               mem_we_n,
  output logic               mem_oe_n,
  output logic [LANES-1:0]   lane_en_n,
  output logic [LANES*8-1:0] mem_dq_out,
  output logic               mem_dq_oe,
  output logic               rsp_valid,
  output logic [LANES*8-1:0] rsp_rdata
);

  logic [AW-1:0]      addr_q;
  logic [LANES*8-1:0] wdata_q;
  logic [LANES-1:0]   be_q, be_d;
  logic               active_d, oe_n_d, we_n_d, dq_oe_d;
  logic               ce_n_q, ce2_q, oe_n_q, we_n_q, dq_oe_q, rsp_q;

  always_comb begin
    active_d = (st_d == ST_READ) || (st_d == ST_WPULSE) || (st_d == ST_WEND);
    oe_n_d   = (st_d != ST_READ);
    we_n_d   = (st_d != ST_WPULSE);
    dq_oe_d  = (st_d == ST_WPULSE) || (st_d == ST_WEND);
    be_d     = start ? req_be : be_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q  <= 1'b1;
      ce2_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      ce_n_q  <= !active_d;
      ce2_q   <= active_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
      rsp_q   <= cap_en;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       en_n_q;
    logic [7:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_n_q <= 1'b1;
      else        en_n_q <= !(active_d && be_d[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= '0;
      else if (cap_en) rd_q <= be_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    end

    assign lane_en_n[g]        = en_n_q;
    assign rsp_rdata[g*8 +: 8] = rd_q;
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_ce2    = ce2_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;
  assign rsp_valid  = rsp_q;

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R6
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr)); // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_ce2 && mem_we_n)); // R2

endmodule

// File: rtl/psram_lane_ctrl.sv
module psram_lane_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_ACE_NS = 70,
  parameter int unsigned T_DOE_NS = 35,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_PWE_NS = 45,
  parameter int unsigned T_SD_NS  = 45,
  parameter int unsigned T_SCE_NS = 60,
  parameter int unsigned T_AW_NS  = 60,
  parameter int unsigned T_BW_NS  = 60,
  parameter int unsigned T_HZ_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_bhe_n,
  output logic              mem_ble_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  localparam int unsigned LANES   = 2;
  localparam int unsigned N_ACC   = umax(umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_ACE_NS, CLK_NS)),
                                         ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned N_RD    = umax(umax(N_ACC, ns_to_cyc(T_RC_NS, CLK_NS)), 1);
  localparam int unsigned N_PWIDE = umax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int unsigned N_SETUP = umax(umax(ns_to_cyc(T_SCE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                         ns_to_cyc(T_BW_NS, CLK_NS));
  localparam int unsigned N_WP    = umax(umax(N_PWIDE, N_SETUP), 1);
  localparam int unsigned N_WCYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_WE    = (N_WCYC > N_WP + 1) ? (N_WCYC - N_WP) : 1;
  localparam int unsigned N_OFF   = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned N_REL   = umax(N_OFF, 1);
  localparam int unsigned N_MAX   = umax(umax(N_RD, N_WP), umax(N_WE, N_REL));
  localparam int unsigned CW      = $clog2(N_MAX + 1);
  localparam int unsigned GW      = $clog2(N_MAX + 2) + 1;

  // reset: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  psram_st_e        st_d;
  logic             start, cap_en;
  logic [LANES-1:0] lane_en_n;

  psram_seq #(
    .N_RD  (N_RD),
    .N_WP  (N_WP),
    .N_WE  (N_WE),
    .N_REL (N_REL),
    .CW    (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .req_ready (req_ready),
    .start     (start),
    .cap_en    (cap_en),
    .st_d      (st_d)
  );

  psram_pin_reg #(
    .AW    (ADDR_W),
    .LANES (LANES)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .st_d       (st_d),
    .start      (start),
    .cap_en     (cap_en),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .lane_en_n  (lane_en_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign mem_ble_n = lane_en_n[0];
  assign mem_bhe_n = lane_en_n[1];

  // window counters used only by the checks below
  logic [GW-1:0] oe_gap_q, we_low_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)           oe_gap_q <= '1;
    else if (!mem_oe_n)        oe_gap_q <= '0;
    else if (oe_gap_q != '1)   oe_gap_q <= oe_gap_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)           we_low_q <= '0;
    else if (mem_we_n)         we_low_q <= '0;
    else if (we_low_q != '1)   we_low_q <= we_low_q + 1'b1;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    req_ready |-> (mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(mem_dq_oe) |-> (oe_gap_q >= GW'(N_OFF))); // R6
  AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(mem_we_n) |-> (we_low_q >= GW'(N_PWIDE))); // R4
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce2 && mem_dq_oe && !(mem_ble_n && mem_bhe_n))); // R5

endmodule

// File: tb/psram_lane_ctrl_test.sv
module psram_lane_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_CYC    = 7;   // 70 ns / 10 ns
  localparam int OFF_CYC    = 3;   // 25 ns rounded up
  localparam int WP_CYC     = 6;   // 60 ns setup dominates 45 ns width
  localparam int RD_BUSY    = 10;  // 7 + 3
  localparam int WR_BUSY    = 7;   // 6 + 1
  localparam int RD_LAT     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid, req_ready, req_write, rsp_valid;
  logic [16:0] req_addr, mem_addr;
  logic [15:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic [1:0]  req_be;
  logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_bhe_n, mem_ble_n, mem_dq_oe;

  psram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bhe_n(mem_bhe_n),
    .mem_ble_n(mem_ble_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  logic [15:0] model_mem [64];
  logic [15:0] shadow    [64];
  int n_chk = 0, n_fail = 0;

  // memory model and pin monitor, sampled mid-cycle
  int   rd_age = 0, oe_gap = 1000, we_len = 0, last_wlen = 0, ce_act = 0;
  int   viol_cont = 0, viol_addr = 0, viol_lane = 0, viol_turn = 0;
  bit   wend_ok = 0;
  logic prev_we_n = 1'b1, prev_rd = 1'b0, prev_dq_oe = 1'b0;
  logic [16:0] prev_addr = '0;
  logic [1:0]  cur_be = 2'b00;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic rd_act = !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n;
      automatic logic [5:0] ix = mem_addr[5:0];
      rd_age = rd_act ? rd_age + 1 : 0;
      mem_dq_in[7:0]  <= (rd_act && !mem_ble_n && rd_age >= ACC_CYC) ? model_mem[ix][7:0]  : 8'h5A;
      mem_dq_in[15:8] <= (rd_act && !mem_bhe_n && rd_age >= ACC_CYC) ? model_mem[ix][15:8] : 8'hC3;
      if (mem_dq_oe && !mem_oe_n) viol_cont++;
      if (rd_act && prev_rd && mem_addr != prev_addr) viol_addr++;
      if (rd_act && (mem_ble_n != !cur_be[0] || mem_bhe_n != !cur_be[1])) viol_lane++;
      if (!mem_oe_n) oe_gap = 0; else if (oe_gap < 1000) oe_gap++;
      if (mem_dq_oe && !prev_dq_oe && oe_gap < OFF_CYC + 1) viol_turn++;
      if (!mem_ce_n || mem_ce2) ce_act++;
      if (!mem_we_n) we_len++;
      if (mem_we_n && !prev_we_n) begin
        last_wlen = we_len;
        we_len = 0;
        wend_ok = !mem_ce_n && mem_ce2 && mem_dq_oe &&
                  (mem_ble_n == !cur_be[0]) && (mem_bhe_n == !cur_be[1]);
        if (!mem_ce_n && mem_ce2) begin
          if (!mem_ble_n) model_mem[ix][7:0]  = mem_dq_out[7:0];
          if (!mem_bhe_n) model_mem[ix][15:8] = mem_dq_out[15:8];
        end
      end
      prev_we_n  = mem_we_n;
      prev_rd    = rd_act;
      prev_dq_oe = mem_dq_oe;
      prev_addr  = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [16:0] a, input bit wr, input logic [15:0] wd,
                        input logic [1:0] be, output int busy, output int lat,
                        output int pulses, output logic [15:0] rd);
    while (!req_ready) @(negedge clk);
    cur_be    = be;
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    req_wdata = wd;
    req_be    = be;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; lat = 0; pulses = 0; rd = '0;
    for (int n = 1; n <= 20; n++) begin
      if (!req_ready) busy++;
      if (rsp_valid) begin
        pulses++;
        if (lat == 0) begin
          lat = n;
          rd  = rsp_rdata;
        end
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [16:0] addr_of(input int i);
    return 17'((i * 7919) * 64 + i * 3);
  endfunction

  function automatic logic [15:0] mask_of(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int busy, lat, pulses, ce0;
    logic [15:0] rd, d, exp;
    for (int k = 0; k < 64; k++) begin
      model_mem[k] = '0;
      shadow[k]    = '0;
    end
    mem_dq_in = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(mem_ce_n == 1'b1 && mem_ce2 == 1'b0, "R1", "chip selects idle", {mem_ce_n, mem_ce2}, 2'b10);
    chk(mem_oe_n && mem_we_n, "R1", "oe/we idle", {mem_oe_n, mem_we_n}, 2'b11);
    chk(mem_ble_n && mem_bhe_n, "R1", "lane enables idle", {mem_bhe_n, mem_ble_n}, 2'b11);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1", "bus/ready/rsp",
        {mem_dq_oe, req_ready, rsp_valid}, 3'b010);

    // R8 read with no lanes
    ce0 = ce_act;
    do_req(addr_of(5), 1'b0, 16'h0, 2'b00, busy, lat, pulses, rd);
    chk(busy == 0, "R8", "noop read ready low cycles", busy, 0);
    chk(pulses == 0, "R8", "noop read responses", pulses, 0);
    chk(ce_act == ce0, "R8", "noop read chip-select cycles", ce_act - ce0, 0);

    for (int bw = 0; bw < 4; bw++) begin
      for (int i = 0; i < 16; i++) begin
        d   = 16'((i * 4951 + bw * 9320 + 257) & 16'hFFFF);
        ce0 = ce_act;
        do_req(addr_of(i), 1'b1, d, 2'(bw), busy, lat, pulses, rd);
        if (bw == 0) begin
          chk(busy == 0, "R8", "noop write ready low cycles", busy, 0);
          chk(ce_act == ce0, "R8", "noop write chip-select cycles", ce_act - ce0, 0);
        end else begin
          chk(busy == WR_BUSY, "R7", "write ready low cycles", busy, WR_BUSY);
          chk(last_wlen == WP_CYC, "R4", "write strobe cycles", last_wlen, WP_CYC);
          chk(wend_ok, "R5", "selects held at strobe rise", wend_ok, 1);
          chk(pulses == 0, "R4", "write produced response", pulses, 0);
          shadow[addr_of(i) % 64] = (shadow[addr_of(i) % 64] & ~mask_of(2'(bw))) | (d & mask_of(2'(bw)));
        end
      end
      for (int i = 0; i < 16; i++) begin
        for (int br = 1; br < 4; br++) begin
          do_req(addr_of(i), 1'b0, 16'h0, 2'(br), busy, lat, pulses, rd);
          exp = shadow[addr_of(i) % 64] & mask_of(2'(br));
          chk(rd == exp, "R4", "read-back word (disabled lanes zero, R3)", rd, exp);
          chk(lat == RD_LAT && pulses == 1, "R3", "response cycle and pulse count",
              lat * 16 + pulses, RD_LAT * 16 + 1);
          chk(busy == RD_BUSY, "R7", "read ready low cycles", busy, RD_BUSY);
        end
      end
    end

    chk(viol_cont == 0, "R6", "cycles driving bus with OE low", viol_cont, 0);
    chk(viol_turn == 0, "R6", "drive starts inside release window", viol_turn, 0);
    chk(viol_addr == 0, "R2", "address changes during read", viol_addr, 0);
    chk(viol_lane == 0, "R2", "lane enable mismatches during read", viol_lane, 0);
    summary();
    $finish;
  end

endmodule